// File: doc/BRIEF.md
# Serial Flash Protocol Mode Controller

This block decides which serial protocol a flash device front end speaks: extended single-line, dual-line or quad-line. It does not shift any bits itself. It tells the shifter and the pad logic how many data lines each transaction phase (instruction, address, data) uses. It also tells them whether the write-protect and hold pins keep their normal functions.

The mode comes from two configuration sources.

- **Stored word.** A non-volatile configuration word is presented by the array while power-on reset is held. The block captures it and uses it to seed the working configuration.
- **Volatile register.** Writes to the volatile register can change the mode afterwards. A new value is held as pending until chip select rises, so it never lands in the middle of a transaction.

A high-voltage program/erase indication overrides the stored mode and forces the extended protocol. This indication is observed through a synchronizer and only while the device is deselected. The configured mode returns as soon as the indication drops.

Top module: `sflash_mode_ctrl`

## Requirements
- R1: While `por_n` is low the mode is loaded from `nvcfg_boot`. Bit 3 = 0 gives quad. Otherwise bit 2 = 0 gives dual. Otherwise the mode is extended, so the erased word 16'hFFFF gives extended.
- R2: When both enable bits of a source are clear, quad wins. In the volatile register these are bit 7 (quad, active low) and bit 6 (dual, active low); in the boot word they are bits 3 and 2.
- R3: A volatile write (`vcfg_wr` high, data on `vcfg_wdata`) made while `cs_n` is low does not change any output while `cs_n` stays low. The lane outputs never change during a cycle pair in which `cs_n` is low.
- R4: A pending volatile value takes effect at the first clock edge that samples `cs_n` high. The new lane widths are visible right after that edge.
- R5: The lane outputs carry the line count as a binary number: extended gives 1/1/1, dual gives 2/2/2 and quad gives 4/4/4 for instruction/address/data.
- R6: While `cs_n` is high, `vpp_high` held high forces extended mode after `SYNC_STAGES`+1 clock edges. Once it is low again, the configured mode returns with the same latency.
- R7: A change of `vpp_high` while `cs_n` is low has no effect on the outputs until `cs_n` rises.
- R8: `wp_fn_en` and `hold_fn_en` are 0 exactly when the active mode is quad and `cs_n` is low; otherwise both are 1.
- R9: A power-on reset discards any volatile setting and restores the mode given by `nvcfg_boot`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, sampled on `clk` |
| cs_n | input | 1 | Chip select, active low, synchronous to `clk` |
| vpp_high | input | 1 | High-voltage program/erase in progress (asynchronous) |
| vcfg_wr | input | 1 | Volatile configuration write strobe |
| vcfg_wdata | input | VCFG_W | Volatile configuration write data |
| nvcfg_boot | input | NVCFG_W | Stored non-volatile configuration word |
| inst_lanes | output | 3 | Line count for the instruction phase |
| addr_lanes | output | 3 | Line count for the address phase |
| data_lanes | output | 3 | Line count for the data phase |
| wp_fn_en | output | 1 | Write-protect pin keeps its function |
| hold_fn_en | output | 1 | Hold/reset pin keeps its function |

## Verification
Power-on is run with four boot words:

- the erased word;
- a word with only the dual bit clear;
- a word with only the quad bit clear;
- a word with both bits clear.

Together they separate decode errors from priority errors.

Volatile writes are issued inside a selected transaction. The outputs are checked twice:

- while select is still low, which catches early application;
- exactly one edge after select rises, which catches extra or missing latency.

The high-voltage indication is toggled in two ways: once with the device deselected, which shows the fallback and the return to quad; and once while selected, which shows that it is deferred. A final power cycle after a volatile write shows that the volatile state is discarded.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

   typedef enum logic [1:0] {
      MODE_EXT  = 2'd0,
      MODE_DUAL = 2'd1,
      MODE_QUAD = 2'd2
   } proto_mode_e;

   localparam int LANE_W         = 3;
   localparam int NUM_PHASES     = 3;
   localparam int VCFG_QUAD_BIT  = 7;
   localparam int VCFG_DUAL_BIT  = 6;
   localparam int NVCFG_QUAD_BIT = 3;
   localparam int NVCFG_DUAL_BIT = 2;

   function automatic proto_mode_e pick_mode(input logic quad_n, input logic dual_n);
      if (!quad_n)      return MODE_QUAD;
      else if (!dual_n) return MODE_DUAL;
      else              return MODE_EXT;
   endfunction

   function automatic logic [LANE_W-1:0] lane_count(input proto_mode_e m);
      case (m)
         MODE_QUAD: return 3'd4;
         MODE_DUAL: return 3'd2;
         default:   return 3'd1;
      endcase
   endfunction

endpackage

// File: rtl/sfm_sync.sv
module sfm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk) begin
            if (!por_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2+1-1:0], d};
         end
         assign q = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sfm_vcfg_reg.sv
module sfm_vcfg_reg (
   input  logic clk,
   input  logic por_n,
   input  logic cs_n,
   input  logic wr,
   input  logic wr_quad_n,
   input  logic wr_dual_n,
   input  logic boot_quad_n,
   input  logic boot_dual_n,
   output logic next_quad_n,
   output logic next_dual_n
);
   logic [1:0] live_q;
   logic [1:0] pend_q;
   logic       pend_vld_q;

   always_ff @(posedge clk) begin
      if (!por_n) begin
         live_q     <= {boot_quad_n, boot_dual_n};
         pend_q     <= {boot_quad_n, boot_dual_n};
         pend_vld_q <= 1'b0;
      end else if (wr) begin
         pend_q     <= {wr_quad_n, wr_dual_n};
         pend_vld_q <= 1'b1;
      end else if (cs_n && pend_vld_q) begin
         live_q     <= pend_q;
         pend_vld_q <= 1'b0;
      end
   end

   // Value the mode register adopts when the device is deselected.
   assign next_quad_n = pend_vld_q ? pend_q[1] : live_q[1];
   assign next_dual_n = pend_vld_q ? pend_q[0] : live_q[0];
endmodule

// File: rtl/sfm_lane_map.sv
module sfm_lane_map
   import sfm_pkg::*;
(
   input  proto_mode_e               mode,
   input  logic                      cs_n,
   output logic [NUM_PHASES*LANE_W-1:0] lanes,
   output logic                      wp_fn_en,
   output logic                      hold_fn_en
);
   generate
      for (genvar ph = 0; ph < NUM_PHASES; ph++) begin : g_phase
         assign lanes[ph*LANE_W +: LANE_W] = lane_count(mode);
      end
   endgenerate

   logic pins_taken;
   assign pins_taken = (mode == MODE_QUAD) && !cs_n;
   assign wp_fn_en   = !pins_taken;
   assign hold_fn_en = !pins_taken;
endmodule

// File: rtl/sflash_mode_ctrl.sv
module sflash_mode_ctrl
   import sfm_pkg::*;
#(
   parameter int VCFG_W      = 8,
   parameter int NVCFG_W     = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               cs_n,
   input  logic               vpp_high,
   input  logic               vcfg_wr,
   input  logic [VCFG_W-1:0]  vcfg_wdata,
   input  logic [NVCFG_W-1:0] nvcfg_boot,
   output logic [LANE_W-1:0]  inst_lanes,
   output logic [LANE_W-1:0]  addr_lanes,
   output logic [LANE_W-1:0]  data_lanes,
   output logic               wp_fn_en,
   output logic               hold_fn_en
);
   localparam int PH_INST = 0;
   localparam int PH_ADDR = 1;
   localparam int PH_DATA = 2;

   generate
      if (VCFG_W <= VCFG_QUAD_BIT) begin : g_bad_vcfg
         $error("VCFG_W too small for the mode bits");
      end
      if (NVCFG_W <= NVCFG_QUAD_BIT) begin : g_bad_nvcfg
         $error("NVCFG_W too small for the mode bits");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0..4");
      end
   endgenerate

   logic cfg_bits_unused;
   assign cfg_bits_unused = ^{vcfg_wdata, nvcfg_boot};

   logic vpp_s;
   sfm_sync #(.STAGES(SYNC_STAGES)) u_vpp_sync (
      .clk   (clk),
      .por_n (por_n),
      .d     (vpp_high),
      .q     (vpp_s)
   );

   logic next_quad_n, next_dual_n;
   sfm_vcfg_reg u_vcfg (
      .clk         (clk),
      .por_n       (por_n),
      .cs_n        (cs_n),
      .wr          (vcfg_wr),
      .wr_quad_n   (vcfg_wdata[VCFG_QUAD_BIT]),
      .wr_dual_n   (vcfg_wdata[VCFG_DUAL_BIT]),
      .boot_quad_n (nvcfg_boot[NVCFG_QUAD_BIT]),
      .boot_dual_n (nvcfg_boot[NVCFG_DUAL_BIT]),
      .next_quad_n (next_quad_n),
      .next_dual_n (next_dual_n)
   );

   proto_mode_e mode_q;
   always_ff @(posedge clk) begin
      if (!por_n)
         mode_q <= pick_mode(nvcfg_boot[NVCFG_QUAD_BIT], nvcfg_boot[NVCFG_DUAL_BIT]);
      else if (cs_n)
         mode_q <= vpp_s ? MODE_EXT : pick_mode(next_quad_n, next_dual_n);
   end

   logic [NUM_PHASES*LANE_W-1:0] lanes;
   sfm_lane_map u_map (
      .mode       (mode_q),
      .cs_n       (cs_n),
      .lanes      (lanes),
      .wp_fn_en   (wp_fn_en),
      .hold_fn_en (hold_fn_en)
   );

   assign inst_lanes = lanes[PH_INST*LANE_W +: LANE_W];
   assign addr_lanes = lanes[PH_ADDR*LANE_W +: LANE_W];
   assign data_lanes = lanes[PH_DATA*LANE_W +: LANE_W];
endmodule

// File: rtl/sflash_mode_ctrl_chk.sv
module sflash_mode_ctrl_chk #(
   parameter int SYNC_STAGES = 2
) (
   input logic       clk,
   input logic       por_n,
   input logic       cs_n,
   input logic       vpp_high,
   input logic [2:0] inst_lanes,
   input logic [2:0] addr_lanes,
   input logic [2:0] data_lanes,
   input logic       wp_fn_en,
   input logic       hold_fn_en
);
   logic [1:0] up_cnt;
   logic [3:0] vpp_cnt;

   always_ff @(posedge clk) begin
      if (!por_n) begin
         up_cnt  <= '0;
         vpp_cnt <= '0;
      end else begin
         if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
         if (!vpp_high)             vpp_cnt <= '0;
         else if (vpp_cnt != 4'hF)  vpp_cnt <= vpp_cnt + 4'd1;
      end
   end

   p_stable_sel_r3: assert property (@(posedge clk) disable iff (!por_n)
      (up_cnt == 2'd3 && !cs_n && $past(!cs_n)) |->
         ($stable(inst_lanes) && $stable(addr_lanes) && $stable(data_lanes)));

   p_lane_legal_r5: assert property (@(posedge clk) disable iff (!por_n)
      (up_cnt != 2'd0) |-> ($countones(inst_lanes) == 1 && inst_lanes != 3'd0
         && inst_lanes == addr_lanes && addr_lanes == data_lanes));

   p_vpp_ext_r6: assert property (@(posedge clk) disable iff (!por_n)
      (up_cnt == 2'd3 && int'(vpp_cnt) >= SYNC_STAGES + 3 && $past(cs_n)) |->
         (inst_lanes == 3'd1));

   p_pins_quad_r8: assert property (@(posedge clk) disable iff (!por_n)
      (up_cnt != 2'd0 && !cs_n && inst_lanes == 3'd4) |-> (!wp_fn_en && !hold_fn_en));

   p_pins_idle_r8: assert property (@(posedge clk) disable iff (!por_n)
      (up_cnt != 2'd0 && cs_n) |-> (wp_fn_en && hold_fn_en));
endmodule

bind sflash_mode_ctrl sflash_mode_ctrl_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk        (clk),
   .por_n      (por_n),
   .cs_n       (cs_n),
   .vpp_high   (vpp_high),
   .inst_lanes (inst_lanes),
   .addr_lanes (addr_lanes),
   .data_lanes (data_lanes),
   .wp_fn_en   (wp_fn_en),
   .hold_fn_en (hold_fn_en)
);

// File: tb/sflash_mode_ctrl_tb.sv
module sflash_mode_ctrl_tb;
   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        vpp_high = 1'b0;
   logic        vcfg_wr = 1'b0;
   logic [7:0]  vcfg_wdata = 8'hFF;
   logic [15:0] nvcfg_boot = 16'hFFFF;
   logic [2:0]  inst_lanes, addr_lanes, data_lanes;
   logic        wp_fn_en, hold_fn_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   sflash_mode_ctrl u_dut (
      .clk        (clk),
      .por_n      (por_n),
      .cs_n       (cs_n),
      .vpp_high   (vpp_high),
      .vcfg_wr    (vcfg_wr),
      .vcfg_wdata (vcfg_wdata),
      .nvcfg_boot (nvcfg_boot),
      .inst_lanes (inst_lanes),
      .addr_lanes (addr_lanes),
      .data_lanes (data_lanes),
      .wp_fn_en   (wp_fn_en),
      .hold_fn_en (hold_fn_en)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_lanes(input string req, input int n);
      chk({req, " inst"}, inst_lanes, n);
      chk({req, " addr"}, addr_lanes, n);
      chk({req, " data"}, data_lanes, n);
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic power_on(input logic [15:0] word);
      @(negedge clk);
      por_n = 1'b0; cs_n = 1'b1; vpp_high = 1'b0; nvcfg_boot = word;
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      edges(2);
   endtask

   task automatic vwrite(input logic [7:0] d);
      @(negedge clk);
      vcfg_wr = 1'b1; vcfg_wdata = d;
      @(negedge clk);
      vcfg_wr = 1'b0;
   endtask

   task automatic t_por_modes();
      power_on(16'hFFFF);
      chk_lanes("R1 erased word ext", 1);
      chk("R8 pins idle", wp_fn_en & hold_fn_en, 1);
      power_on(16'hFFFB);
      chk_lanes("R1 dual boot / R5", 2);
      power_on(16'hFFF7);
      chk_lanes("R1 quad boot / R5", 4);
      power_on(16'hFFF3);
      chk_lanes("R2 boot both clear quad", 4);
   endtask

   task automatic t_vcfg_deferred();
      power_on(16'hFFFF);
      @(negedge clk); cs_n = 1'b0;
      vwrite(8'hBF);
      edges(4);
      chk_lanes("R3 held while selected", 1);
      @(negedge clk); cs_n = 1'b1;
      edges(1);
      chk_lanes("R4 applied one edge after rise", 2);
   endtask

   task automatic t_quad_priority_pins();
      @(negedge clk); cs_n = 1'b0;
      vwrite(8'h3F);
      @(negedge clk); cs_n = 1'b1;
      edges(2);
      chk_lanes("R2 volatile both clear quad", 4);
      chk("R8 quad deselected wp", wp_fn_en, 1);
      @(negedge clk); cs_n = 1'b0;
      #1;
      chk("R8 quad selected wp", wp_fn_en, 0);
      chk("R8 quad selected hold", hold_fn_en, 0);
      @(negedge clk); cs_n = 1'b1;
      #1;
      chk("R8 quad released hold", hold_fn_en, 1);
   endtask

   task automatic t_vpp_fallback();
      @(negedge clk); vpp_high = 1'b1;
      edges(2);
      chk_lanes("R6 not before sync latency", 4);
      edges(1);
      chk_lanes("R6 fallback to ext", 1);
      @(negedge clk); cs_n = 1'b0;
      #1;
      chk("R8 ext selected wp", wp_fn_en, 1);
      @(negedge clk); cs_n = 1'b1;
      vpp_high = 1'b0;
      edges(3);
      chk_lanes("R6 quad resumes", 4);
   endtask

   task automatic t_vpp_selected();
      @(negedge clk); cs_n = 1'b0; vpp_high = 1'b1;
      edges(6);
      chk_lanes("R7 vpp ignored while selected", 4);
      @(negedge clk); cs_n = 1'b1;
      edges(1);
      chk_lanes("R7 vpp seen after release", 1);
      @(negedge clk); vpp_high = 1'b0;
      edges(4);
      chk_lanes("R7 back to quad", 4);
   endtask

   task automatic t_power_cycle();
      @(negedge clk); cs_n = 1'b0;
      vwrite(8'h7F);
      @(negedge clk); cs_n = 1'b1;
      edges(2);
      power_on(16'hFFFB);
      chk_lanes("R9 volatile discarded", 2);
   endtask

   initial begin
      t_por_modes();
      t_vcfg_deferred();
      t_quad_priority_pins();
      t_vpp_fallback();
      t_vpp_selected();
      t_power_cycle();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule